// File: doc/BRIEF.md
# Three-Bank GPIO Controller with Edge and Level Interrupts

This block is a memory-mapped general-purpose I/O controller. It serves three banks of 32 pins through a plain 32-bit register port: an address, a write strobe, write data, and registered read data. For each pin, software sets the direction. It moves the output latch only through separate write-one-to-set and write-one-to-clear words. It reads the pin levels after a two-flop synchronizer.

Each pin has four independent event sources: a rising edge, a falling edge, a high level and a low level. All four act on the pin after an optional per-pin inversion. An event latches a sticky status bit. Software clears that bit by writing a one to it. A companion register records which status bits came from an edge. One interrupt line is high while any status bit in any bank is set. Pad drivers and pin muxing sit outside the block.

Top module: `gpio_ctrl`

## Requirements
- R1: The byte address is function*0x10 + bank*4, with the function index in this order: 0 direction, 1 invert, 2 pin data, 3 set, 4 clear, 5 rise enable, 6 fall enable, 7 high enable, 8 low enable, 9 status, 10 edge-source. The read data for an address presented before a clock edge appears on bus_rdata after that edge. Registers 0, 1 and 5 to 8 read back the value last written.
- R2: A 1 in a direction bit drives pin_oe high for that pin; a 0 leaves the pin as an input.
- R3: Writing to set raises each output bit written as 1. Writing to clear lowers each output bit written as 1. Bits written as 0 keep their value. Set and clear read back as zero.
- R4: Reading the pin data register returns the bank's synchronized input levels, without inversion. A pin change is readable from the fourth clock edge after it.
- R5: With rise enable set, a 0-to-1 change of the (possibly inverted) pin level sets its status bit. With only rise enable set, a 1-to-0 change sets nothing.
- R6: With fall enable set, a 1-to-0 change of the (possibly inverted) pin level sets its status bit.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it. A new event in the same cycle as the clear wins, so the bit stays set. Status never drops without a write.
- R8: An invert bit of 1 flips the sampled pin before edge and level detection, so a raw rising pin is seen as a falling one.
- R9: While high (low) enable is set and the inverted pin is high (low), the status bit is held set and a clear does not remove it.
- R10: The edge-source register reads 1 for a status bit set by an edge and 0 for a status bit set only by a level. Write-one-to-clear on status clears it too.
- R11: irq is high exactly while at least one status bit in any bank is set.
- R12: Writes to bank number 3, to function indices 11 to 15, and to the pin data and edge-source registers change nothing. Reads of bank 3 or of function indices 11 to 15 return zero.
- R13: Reset clears every register, so pin_oe, pin_out and irq are zero and every readable register returns zero with the pins low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| pin_in | input | 96 | Raw pin levels, global pin n is bank n/32 bit n%32 |
| pin_out | output | 96 | Output latch per pin |
| pin_oe | output | 96 | Output enable per pin (direction) |
| irq | output | 1 | Combined interrupt, high while any status bit is set |

## Verification
Register writes and readbacks spread over all three banks. Each function is given a distinct pattern, which shows whether the function and bank fields of the address are decoded in the right order. Bank 3 and unmapped functions are written with all ones, which would show any aliasing. Single pins are toggled with only one of rise or fall enabled. A rise is sent through an inverted pin, which separates edge direction from polarity. A pin change is timed to meet a status clear in the same cycle, which checks that the new event wins. Level enables are held against repeated clears, and the edge-source register is read after both kinds of event, which tells level-set bits from edge-set bits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NFN     = 11;
    localparam int FN_BITS = 4;

    typedef enum logic [FN_BITS-1:0] {
        FN_DIR  = 4'd0,
        FN_INV  = 4'd1,
        FN_PINS = 4'd2,
        FN_SET  = 4'd3,
        FN_CLR  = 4'd4,
        FN_RISE = 4'd5,
        FN_FALL = 4'd6,
        FN_HIGH = 4'd7,
        FN_LOW  = 4'd8,
        FN_STAT = 4'd9,
        FN_SRC  = 4'd10
    } gpio_fn_e;

endpackage

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NFN-1:0]      wr_sel,
    input  logic [W-1:0]        wdata,
    input  logic [W-1:0]        pin_i,
    output logic [NFN-1:0][W-1:0] rd_words,
    output logic [W-1:0]        dir_o,
    output logic [W-1:0]        out_o,
    output logic                any_o
);

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] inv;
        logic [W-1:0] dout;
        logic [W-1:0] ren;
        logic [W-1:0] fen;
        logic [W-1:0] hen;
        logic [W-1:0] len;
        logic [W-1:0] stat;
        logic [W-1:0] src;
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [W-1:0] lvl, edge_ev, lvl_ev, w1c;

    always_comb begin
        st_d    = st_q;
        lvl     = st_q.s2 ^ st_q.inv;
        edge_ev = (lvl & ~st_q.prev & st_q.ren) | (~lvl & st_q.prev & st_q.fen);
        lvl_ev  = (lvl & st_q.hen) | (~lvl & st_q.len);
        w1c     = wr_sel[FN_STAT] ? wdata : '0;

        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = lvl;

        if (wr_sel[FN_DIR])  st_d.dir = wdata;
        if (wr_sel[FN_INV])  st_d.inv = wdata;
        if (wr_sel[FN_RISE]) st_d.ren = wdata;
        if (wr_sel[FN_FALL]) st_d.fen = wdata;
        if (wr_sel[FN_HIGH]) st_d.hen = wdata;
        if (wr_sel[FN_LOW])  st_d.len = wdata;
        if (wr_sel[FN_SET])  st_d.dout = st_q.dout | wdata;
        if (wr_sel[FN_CLR])  st_d.dout = st_q.dout & ~wdata;

        st_d.stat = (st_q.stat & ~w1c) | edge_ev | lvl_ev;
        st_d.src  = (st_q.src & ~w1c) | edge_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_words          = '0;
        rd_words[FN_DIR]  = st_q.dir;
        rd_words[FN_INV]  = st_q.inv;
        rd_words[FN_PINS] = st_q.s2;
        rd_words[FN_RISE] = st_q.ren;
        rd_words[FN_FALL] = st_q.fen;
        rd_words[FN_HIGH] = st_q.hen;
        rd_words[FN_LOW]  = st_q.len;
        rd_words[FN_STAT] = st_q.stat;
        rd_words[FN_SRC]  = st_q.src;
    end

    assign dir_o = st_q.dir;
    assign out_o = st_q.dout;
    assign any_o = |st_q.stat;

endmodule

// File: rtl/gpio_regsel.sv
module gpio_regsel
    import gpio_pkg::*;
#(
    parameter int NB = 3,
    parameter int W  = 32,
    parameter int BB = 2
) (
    input  logic [NB-1:0][NFN-1:0][W-1:0] words,
    input  logic [FN_BITS-1:0]            fn,
    input  logic [BB-1:0]                 bsel,
    output logic [W-1:0]                  rdata
);

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NB; b++) begin
            for (int f = 0; f < NFN; f++) begin
                if (bsel == BB'(b) && fn == FN_BITS'(f)) rdata = words[b][f];
            end
        end
    end

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NBANK = 3,
    parameter int BANKW = 32,
    parameter int AW    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          bus_addr,
    input  logic                   bus_we,
    input  logic [BANKW-1:0]       bus_wdata,
    output logic [BANKW-1:0]       bus_rdata,
    input  logic [NBANK*BANKW-1:0] pin_in,
    output logic [NBANK*BANKW-1:0] pin_out,
    output logic [NBANK*BANKW-1:0] pin_oe,
    output logic                   irq
);

    localparam int BB     = 2;
    localparam int BS_LSB = 2;
    localparam int FN_LSB = BS_LSB + BB;

    typedef struct packed {
        logic [BANKW-1:0] rdata;
    } top_st_t;

    top_st_t top_d, top_q;

    logic [FN_BITS-1:0] fn;
    logic [BB-1:0]      bsel;
    logic [NBANK-1:0][NFN-1:0][BANKW-1:0] words;
    logic [NBANK-1:0][NFN-1:0] wr_sel;
    logic [NBANK-1:0]   bank_any;
    logic [BANKW-1:0]   rd_mux;

    assign fn   = bus_addr[FN_LSB +: FN_BITS];
    assign bsel = bus_addr[BS_LSB +: BB];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_comb begin
            wr_sel[b] = '0;
            if (bus_we && bsel == BB'(b) && 32'(fn) < NFN) wr_sel[b] = NFN'(1) << fn;
        end

        gpio_bank #(.W(BANKW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wr_sel[b]),
            .wdata    (bus_wdata),
            .pin_i    (pin_in[b*BANKW +: BANKW]),
            .rd_words (words[b]),
            .dir_o    (pin_oe[b*BANKW +: BANKW]),
            .out_o    (pin_out[b*BANKW +: BANKW]),
            .any_o    (bank_any[b])
        );
    end

    gpio_regsel #(.NB(NBANK), .W(BANKW), .BB(BB)) u_sel (
        .words (words),
        .fn    (fn),
        .bsel  (bsel),
        .rdata (rd_mux)
    );

    always_comb begin
        top_d       = top_q;
        top_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign bus_rdata = top_q.rdata;
    assign irq       = |bank_any;

endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
    parameter int NBANK = 3,
    parameter int BANKW = 32,
    parameter int AW    = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [AW-1:0]          bus_addr,
    input logic                   bus_we,
    input logic [BANKW-1:0]       bus_wdata,
    input logic [NBANK*BANKW-1:0] pin_out,
    input logic [NBANK*BANKW-1:0] pin_oe,
    input logic                   irq
);

    for (genvar b = 0; b < NBANK; b++) begin : g_chk
        AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && bus_addr == AW'(8'h30 + 4*b)) |=> ((pin_out[b*BANKW +: BANKW] & $past(bus_wdata)) == $past(bus_wdata))); // R3
        AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && bus_addr == AW'(8'h40 + 4*b)) |=> ((pin_out[b*BANKW +: BANKW] & $past(bus_wdata)) == '0)); // R3
        AST_DIR_LOADS: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && bus_addr == AW'(4*b)) |=> (pin_oe[b*BANKW +: BANKW] == $past(bus_wdata))); // R2
    end

    AST_BANK3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && bus_addr[3:2] == 2'd3) |=> ($stable(pin_out) && $stable(pin_oe))); // R12
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (!bus_we && irq) |=> irq); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq)); // R13

endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NBANK(NBANK), .BANKW(BANKW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
);

// File: tb/gpio_ctrl_test.sv
module gpio_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [95:0] pin_in = '0;
    logic [95:0] pin_out, pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rd_val;

    always #5 clk = ~clk;

    gpio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'h00, 32'hA5A5_0F0F},
        '{1'b0, 8'h00, 32'hA5A5_0F0F},
        '{1'b1, 8'h14, 32'h1234_5678},
        '{1'b0, 8'h14, 32'h1234_5678},
        '{1'b0, 8'h10, 32'h0000_0000},
        '{1'b1, 8'h38, 32'hF000_000F},
        '{1'b1, 8'h48, 32'h0000_0003},
        '{1'b1, 8'h58, 32'h0000_00FF},
        '{1'b0, 8'h58, 32'h0000_00FF},
        '{1'b1, 8'h0C, 32'hFFFF_FFFF},
        '{1'b0, 8'h0C, 32'h0000_0000},
        '{1'b1, 8'hB0, 32'hFFFF_FFFF},
        '{1'b0, 8'hB0, 32'h0000_0000},
        '{1'b0, 8'h38, 32'h0000_0000},
        '{1'b1, 8'h64, 32'h0000_FFFF},
        '{1'b0, 8'h64, 32'h0000_FFFF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        rd_val = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] acc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        check("R13 pin_oe", pin_oe[31:0] | pin_oe[63:32] | pin_oe[95:64], 32'h0);
        check("R13 pin_out", pin_out[31:0] | pin_out[63:32] | pin_out[95:64], 32'h0);
        check("R13 irq", {31'h0, irq}, 32'h0);
        acc = '0;
        for (int b = 0; b < 4; b++)
            for (int f = 0; f < 16; f++) begin
                rd(8'(f * 16 + b * 4));
                acc = acc | rd_val;
            end
        check("R13 all registers", acc, 32'h0);

        // R1 R3 R12 table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else begin
                rd(VECS[i].addr);
                check($sformatf("R1/R3/R12 vector %0d", i), rd_val, VECS[i].data);
            end
        end
        check("R2 bank0 oe", pin_oe[31:0], 32'hA5A5_0F0F);
        check("R2 bank1 oe", pin_oe[63:32], 32'h0);
        check("R3 bank2 out", pin_out[95:64], 32'hF000_000C);
        check("R11 idle irq", {31'h0, irq}, 32'h0);

        // R4 pin data read, raw
        pin_in[40] = 1'b1;
        settle();
        rd(8'h24);
        check("R4 pin data", rd_val, 32'h0000_0100);
        check("R5 no rise enable irq", {31'h0, irq}, 32'h0);

        // R6 falling edge, R10 edge source, R7 clear, R11
        pin_in[40] = 1'b0;
        settle();
        rd(8'h94);
        check("R6 fall status", rd_val, 32'h0000_0100);
        check("R11 irq set", {31'h0, irq}, 32'h1);
        rd(8'hA4);
        check("R10 edge source", rd_val, 32'h0000_0100);
        wr(8'h94, 32'h0000_0100);
        rd(8'h94);
        check("R7 w1c clears", rd_val, 32'h0);
        rd(8'hA4);
        check("R10 source cleared", rd_val, 32'h0);
        check("R11 irq clear", {31'h0, irq}, 32'h0);

        // R8 inverted pin: raw rise becomes fall
        pin_in[35] = 1'b1;
        settle();
        rd(8'h94);
        check("R8 inverted rise", rd_val, 32'h0000_0008);
        rd(8'h24);
        check("R4 raw ignores invert", rd_val, 32'h0000_0008);
        wr(8'h94, 32'h0000_0008);
        pin_in[35] = 1'b0;
        settle();
        rd(8'h94);
        check("R8 inverted fall ignored", rd_val, 32'h0);

        // R5 rising only
        pin_in[64] = 1'b1;
        settle();
        rd(8'h98);
        check("R5 rise status", rd_val, 32'h0000_0001);
        wr(8'h98, 32'h0000_0001);
        pin_in[64] = 1'b0;
        settle();
        rd(8'h98);
        check("R5 fall not enabled", rd_val, 32'h0);

        // R7 event coinciding with clear
        pin_in[65] = 1'b1;
        settle();
        rd(8'h98);
        check("R7 first event", rd_val, 32'h0000_0002);
        pin_in[65] = 1'b0;
        settle();
        pin_in[65] = 1'b1;
        @(negedge clk);
        wr(8'h98, 32'h0000_0002);
        rd(8'h98);
        check("R7 event wins over clear", rd_val, 32'h0000_0002);
        wr(8'h98, 32'h0000_0000);
        rd(8'h98);
        check("R7 zero write keeps", rd_val, 32'h0000_0002);
        wr(8'h98, 32'h0000_0002);
        rd(8'h98);
        check("R7 cleared", rd_val, 32'h0);

        // R9 level high held, R10 level not edge
        wr(8'h70, 32'h0000_0010);
        pin_in[4] = 1'b1;
        settle();
        rd(8'h90);
        check("R9 high level", rd_val, 32'h0000_0010);
        rd(8'hA0);
        check("R10 level source", rd_val, 32'h0);
        wr(8'h90, 32'h0000_0010);
        rd(8'h90);
        check("R9 held while high", rd_val, 32'h0000_0010);
        pin_in[4] = 1'b0;
        settle();
        wr(8'h90, 32'h0000_0010);
        rd(8'h90);
        check("R9 released", rd_val, 32'h0);

        // R9 low level
        wr(8'h80, 32'h0000_0020);
        repeat (2) @(negedge clk);
        rd(8'h90);
        check("R9 low level", rd_val, 32'h0000_0020);
        check("R11 irq level", {31'h0, irq}, 32'h1);
        wr(8'h80, 32'h0);
        wr(8'h90, 32'h0000_0020);
        rd(8'h90);
        check("R9 low released", rd_val, 32'h0);
        check("R11 irq off", {31'h0, irq}, 32'h0);

        // R12 writes to pin data and edge source ignored
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'hA4, 32'hFFFF_FFFF);
        rd(8'h20);
        check("R12 pin data write ignored", rd_val, 32'h0);
        rd(8'hA4);
        check("R12 source write ignored", rd_val, 32'h0);
        check("R12 outputs untouched", pin_out[31:0], 32'h0);

        finish_run();
    end

endmodule